// File: doc/BRIEF.md
# GPIO Bank with Pin Interrupts

This block is one bank of general-purpose pins behind a small 32-bit register bus. Each pin is configured by seven per-pin control registers: output value, interrupt mask, pull-up disable, function enable, select, direction and trigger type. Software changes them only through atomic set and clear aliases. So concurrent drivers never need a read-modify-write sequence.

The function, select, direction and trigger bits of a pin together choose one of four behaviours: plain input, plain output, one of three alternate peripheral functions, or interrupt source. Interrupt sources detect a rising edge, a falling edge, a high level or a low level on the synchronized pin. Detected events latch into a flag register, and unmasked flags raise one shared, registered bank interrupt. Alternate peripherals connect only through per-pin value and enable vectors. Pad electronics stay outside the block.

Top module: `pinbank_irq`

## Requirements
- R1: After reset the mask register reads all ones on implemented pins. Every other control register and the flag register read zero, `irq_out` is 0, `pad_oe` is all zero and `pad_pu_en` is all ones.
- R2: Control registers are read at offsets 0x10 (output value), 0x20 (mask), 0x30 (pull-up disable), 0x40 (function), 0x50 (select), 0x60 (direction) and 0x70 (trigger). Writing to offset+4 sets each bit written as 1, and writing to offset+8 clears each bit written as 1. Bits written as 0 are unchanged. A write to a base offset has no effect.
- R3: Bits at and above `NPINS` read as zero in every register, and writes to them are ignored.
- R4: With function=0 and select=0 a pin is plain I/O: `pad_oe` equals its direction bit and `pad_out` equals its output-value bit. Offset 0x00 returns the pin inputs after a two-flop synchronizer.
- R5: With function=1 a pin follows an alternate source, and `pad_out`/`pad_oe` of pin i come from `alt_dout`/`alt_doe` bit k*NPINS+i. Source k=0 is used when select=0, k=1 when select=1 and trigger=0, and k=2 when select=1 and trigger=1.
- R6: With function=0 and select=1 a pin is an interrupt input with `pad_oe` 0. If trigger=1 it flags a rising edge when direction=1 and a falling edge when direction=0. Clearing the flag while the pin stays at its new level leaves the flag clear.
- R7: For an interrupt input with trigger=0, the flag sets while the synchronized pin equals the direction bit (1 = high, 0 = low). A clear attempted while that level persists leaves the flag set.
- R8: The flag register is read at 0x80 and cleared by writing 1s to 0x84. Only pins in interrupt mode ever set a flag.
- R9: `pad_pu_en` of each pin is the inverse of its pull-up disable bit.
- R10: `irq_out` is the registered OR over all pins of flag AND NOT mask. It is 0 whenever no unmasked flag was present on the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data at `bus_addr` |
| pad_in | input | NPINS | Raw pin levels from the pads |
| pad_out | output | NPINS | Value driven to each pad |
| pad_oe | output | NPINS | Pad output enable |
| pad_pu_en | output | NPINS | Pull-up enable per pad |
| alt_dout | input | 3*NPINS | Alternate-function output values, source k at bits k*NPINS+i |
| alt_doe | input | 3*NPINS | Alternate-function output enables, same layout |
| irq_out | output | 1 | Combined bank interrupt |

## Verification
The bench builds the bank with `NPINS` set to 31, which reproduces a short bank. This makes the top bit of every register an unimplemented position, so the set aliases can be shown to ignore it and the read path can be shown to return zero there. Using 31 also gives `alt_dout`/`alt_doe` an odd width, so any slip in the per-source indexing lands on the wrong pin and is caught. The default of 32 pins compiles the same paths with the width-trimming logic at its limit.

// File: rtl/pinbank_pkg.sv
// Shared constants and types for the GPIO bank.
// Assumes byte offsets on an 8-bit address; control registers sit at
// multiples of 0x10, with +4 set and +8 clear aliases.
package pinbank_pkg;
    localparam int NUM_CTRL = 7;

    // Control register index = (offset >> 4) - 1
    typedef enum logic [2:0] {
        CR_DATA = 3'd0,
        CR_MASK = 3'd1,
        CR_PULL = 3'd2,
        CR_FUNC = 3'd3,
        CR_SEL  = 3'd4,
        CR_DIR  = 3'd5,
        CR_TRIG = 3'd6
    } ctrl_idx_e;

    localparam logic [7:0] OFS_LEVEL     = 8'h00;
    localparam logic [7:0] OFS_FLAG      = 8'h80;
    localparam logic [7:0] OFS_FLAG_CLR  = 8'h84;
    localparam logic [3:0] SUB_SET       = 4'h4;
    localparam logic [3:0] SUB_CLR       = 4'h8;

    typedef enum logic [2:0] {
        MODE_GPIO = 3'd0,
        MODE_IRQ  = 3'd1,
        MODE_ALT1 = 3'd2,
        MODE_ALT2 = 3'd3,
        MODE_ALT3 = 3'd4
    } pin_mode_e;
endpackage

// File: rtl/pinbank_regs.sv
// Control register file: seven per-pin registers written only via
// set/clear aliases, plus the flag-clear strobe decode.
// Assumes bus_we is a single-cycle qualified write strobe.
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               bus_we,
    input  logic [7:0]                         bus_addr,
    input  logic [NPINS-1:0]                   wr_bits,
    output logic [NUM_CTRL-1:0][NPINS-1:0]     ctrl_q,
    output logic [NPINS-1:0]                   flag_clr
);
    localparam logic [NPINS-1:0] ALL_ONES = {NPINS{1'b1}};

    logic [3:0] hi_nib;
    logic       hi_ok;
    logic [2:0] idx;

    // Decode which control register the address selects
    always_comb begin
        hi_nib = bus_addr[7:4];
        hi_ok  = (hi_nib >= 4'd1) && (hi_nib <= 4'd7);
        idx    = 3'(hi_nib - 4'd1);
    end

    // Flag clear strobe from the dedicated alias
    assign flag_clr = (bus_we && bus_addr == OFS_FLAG_CLR) ? wr_bits : '0;

    for (genvar k = 0; k < NUM_CTRL; k++) begin : g_reg
        localparam logic [NPINS-1:0] RST_VAL = (k == int'(CR_MASK)) ? ALL_ONES : '0;
        logic hit;
        assign hit = bus_we && hi_ok && (idx == 3'(k));

        // Apply set or clear alias to register k
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_q[k] <= RST_VAL;
            end else if (hit && bus_addr[3:0] == SUB_SET) begin
                ctrl_q[k] <= ctrl_q[k] | wr_bits;
            end else if (hit && bus_addr[3:0] == SUB_CLR) begin
                ctrl_q[k] <= ctrl_q[k] & ~wr_bits;
            end
        end
    end
endmodule

// File: rtl/pinbank_pin.sv
// One pin: mode decode, output mux, two-flop input synchronizer and
// edge/level event detection. Assumes pad_in is asynchronous.
module pinbank_pin
    import pinbank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pad_in,
    input  logic       data_b,
    input  logic       func_b,
    input  logic       sel_b,
    input  logic       dir_b,
    input  logic       trig_b,
    input  logic [2:0] alt_do,
    input  logic [2:0] alt_oe,
    output logic       pad_out,
    output logic       pad_oe,
    output logic       level,
    output logic       event_o
);
    pin_mode_e mode;
    logic meta_q, sync_q, prev_q;

    // Decode pin mode from function/select/trigger
    always_comb begin
        if (!func_b)      mode = sel_b ? MODE_IRQ : MODE_GPIO;
        else if (!sel_b)  mode = MODE_ALT1;
        else if (!trig_b) mode = MODE_ALT2;
        else              mode = MODE_ALT3;
    end

    // Select output value and enable for the decoded mode
    always_comb begin
        unique case (mode)
            MODE_GPIO: begin pad_out = data_b;    pad_oe = dir_b;     end
            MODE_ALT1: begin pad_out = alt_do[0]; pad_oe = alt_oe[0]; end
            MODE_ALT2: begin pad_out = alt_do[1]; pad_oe = alt_oe[1]; end
            MODE_ALT3: begin pad_out = alt_do[2]; pad_oe = alt_oe[2]; end
            default:   begin pad_out = 1'b0;      pad_oe = 1'b0;      end
        endcase
    end

    // Synchronize the pad and keep one cycle of history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level = sync_q;

    // Event when in interrupt mode and the chosen condition holds
    always_comb begin
        if (mode != MODE_IRQ)  event_o = 1'b0;
        else if (trig_b)       event_o = (sync_q != prev_q) && (sync_q == dir_b);
        else                   event_o = (sync_q == dir_b);
    end
endmodule

// File: rtl/pinbank_flags.sv
// Pending-event flags and the registered combined interrupt.
// A new event wins over a clear in the same cycle.
module pinbank_flags #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] events,
    input  logic [NPINS-1:0] clr,
    input  logic [NPINS-1:0] mask,
    output logic [NPINS-1:0] flag_q,
    output logic             irq_out
);
    // Latch events, drop cleared bits
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr) | events;
    end

    // Register the OR of unmasked flags
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= |(flag_q & ~mask);
    end
endmodule

// File: rtl/pinbank_irq.sv
// GPIO bank top: register file, per-pin logic, flags and read mux.
// Assumes NPINS between 1 and 32; unimplemented bits read zero.
module pinbank_irq
    import pinbank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [7:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NPINS-1:0]     pad_in,
    output logic [NPINS-1:0]     pad_out,
    output logic [NPINS-1:0]     pad_oe,
    output logic [NPINS-1:0]     pad_pu_en,
    input  logic [3*NPINS-1:0]   alt_dout,
    input  logic [3*NPINS-1:0]   alt_doe,
    output logic                 irq_out
);
    logic [NUM_CTRL-1:0][NPINS-1:0] ctrl_q;
    logic [NPINS-1:0] flag_clr, flag_q, events, level;
    logic [NPINS-1:0] mask_q, func_q, sel_q;

    assign mask_q = ctrl_q[CR_MASK];
    assign func_q = ctrl_q[CR_FUNC];
    assign sel_q  = ctrl_q[CR_SEL];
    assign pad_pu_en = ~ctrl_q[CR_PULL];

    pinbank_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .wr_bits(bus_wdata[NPINS-1:0]), .ctrl_q(ctrl_q), .flag_clr(flag_clr)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pinbank_pin u_pin (
            .clk(clk), .rst_n(rst_n), .pad_in(pad_in[i]),
            .data_b(ctrl_q[CR_DATA][i]), .func_b(func_q[i]), .sel_b(sel_q[i]),
            .dir_b(ctrl_q[CR_DIR][i]), .trig_b(ctrl_q[CR_TRIG][i]),
            .alt_do({alt_dout[2*NPINS+i], alt_dout[NPINS+i], alt_dout[i]}),
            .alt_oe({alt_doe[2*NPINS+i], alt_doe[NPINS+i], alt_doe[i]}),
            .pad_out(pad_out[i]), .pad_oe(pad_oe[i]),
            .level(level[i]), .event_o(events[i])
        );
    end

    pinbank_flags #(.NPINS(NPINS)) u_flags (
        .clk(clk), .rst_n(rst_n), .events(events), .clr(flag_clr),
        .mask(mask_q), .flag_q(flag_q), .irq_out(irq_out)
    );

    // Read mux, zero-extended to the bus width
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_LEVEL)
            bus_rdata[NPINS-1:0] = level;
        else if (bus_addr == OFS_FLAG)
            bus_rdata[NPINS-1:0] = flag_q;
        else if (bus_addr[3:0] == 4'h0 && bus_addr[7:4] >= 4'd1 && bus_addr[7:4] <= 4'd7)
            bus_rdata[NPINS-1:0] = ctrl_q[3'(bus_addr[7:4] - 4'd1)];
    end
endmodule

// File: rtl/pinbank_chk.sv
// Assertion checker for pinbank_irq, attached by bind below.
module pinbank_chk #(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] func_q,
    input logic [NPINS-1:0] sel_q,
    input logic [NPINS-1:0] mask_q,
    input logic [NPINS-1:0] flag_q,
    input logic [NPINS-1:0] pad_oe,
    input logic             irq_out,
    input logic [31:0]      bus_rdata
);
    AST_IRQ_PIN_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & sel_q & ~func_q) == '0); // R6

    AST_FLAG_ONLY_IRQ_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & ~$past(flag_q)) & ~$past(sel_q & ~func_q)) == '0); // R8

    AST_NO_SPURIOUS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & ~mask_q) == '0) |=> !irq_out); // R10

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past((flag_q & ~mask_q) != '0)); // R10

    if (NPINS < 32) begin : g_upper
        AST_UNIMPL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rdata[31:NPINS] == '0); // R3
    end
endmodule

bind pinbank_irq pinbank_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .func_q(func_q), .sel_q(sel_q),
    .mask_q(mask_q), .flag_q(flag_q), .pad_oe(pad_oe),
    .irq_out(irq_out), .bus_rdata(bus_rdata)
);

// File: tb/sim_pinbank_irq.sv
// Directed bench for pinbank_irq built as a 31-pin bank.
module sim_pinbank_irq;
    localparam int N = 31;

    logic clk = 0, rst_n = 0, bus_we = 0;
    logic [7:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic [N-1:0] pad_in = '0, pad_out, pad_oe, pad_pu_en;
    logic [3*N-1:0] alt_dout = '0, alt_doe = '0;
    logic irq_out;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pinbank_irq #(.NPINS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu_en(pad_pu_en),
        .alt_dout(alt_dout), .alt_doe(alt_doe), .irq_out(irq_out)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_we = 0; bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h20, v); chk("R1 mask", v, 32'h7fff_ffff);
        for (int k = 1; k <= 7; k++) if (k != 2) begin
            rd(8'(k * 16), v); chk("R1 ctrl", v, 0);
        end
        rd(8'h80, v); chk("R1 flag", v, 0);
        chk("R1 irq", {31'b0, irq_out}, 0);
        chk("R1 oe", {1'b0, pad_oe}, 0);
        chk("R1 pu", {1'b0, pad_pu_en}, 32'h7fff_ffff);
    endtask

    task automatic t_setclr();
        logic [31:0] v;
        wr(8'h14, 32'h8000_00f0); rd(8'h10, v); chk("R2 set, R3 bit31", v, 32'h0000_00f0);
        wr(8'h18, 32'h0000_0030); rd(8'h10, v); chk("R2 clear", v, 32'h0000_00c0);
        wr(8'h10, 32'h0000_0000); rd(8'h10, v); chk("R2 base write ignored", v, 32'h0000_00c0);
        wr(8'h18, 32'hffff_ffff); rd(8'h10, v); chk("R2 clear all", v, 0);
        wr(8'h20, 32'h0); rd(8'h20, v); chk("R2 mask base ignored", v, 32'h7fff_ffff);
        wr(8'h74, 32'h8000_0000); rd(8'h70, v); chk("R3 unimpl ignored", v, 0);
    endtask

    task automatic t_gpio();
        logic [31:0] v;
        wr(8'h64, 32'h0000_0f00); wr(8'h14, 32'h0000_0a00);
        chk("R4 oe", {1'b0, pad_oe}, 32'h0000_0f00);
        chk("R4 out", {20'b0, pad_out[11:0]}, 32'h0000_0a00);
        pad_in[20] = 1; idle(1); rd(8'h00, v); chk("R4 sync not yet", v, 0);
        idle(1); rd(8'h00, v); chk("R4 level", v, 32'h0010_0000);
        pad_in[20] = 0; idle(3);
        wr(8'h68, 32'h0000_0f00); wr(8'h18, 32'h0000_0a00);
    endtask

    task automatic t_pull();
        wr(8'h34, 32'h0000_0020);
        chk("R9 pu", {1'b0, pad_pu_en}, 32'h7fff_ffdf);
        wr(8'h38, 32'h0000_0020);
        chk("R9 pu restored", {1'b0, pad_pu_en}, 32'h7fff_ffff);
    endtask

    task automatic t_alt();
        wr(8'h44, 32'h7); wr(8'h54, 32'h6); wr(8'h74, 32'h4);
        alt_dout = '0; alt_doe = '0;
        alt_dout[0] = 1; alt_doe[0] = 1;
        alt_dout[N+1] = 1; alt_doe[N+1] = 1;
        alt_dout[2*N+2] = 1; alt_doe[2*N+2] = 1;
        #1; chk("R5 out", {29'b0, pad_out[2:0]}, 7);
        chk("R5 oe", {29'b0, pad_oe[2:0]}, 7);
        alt_dout = '0; alt_doe = '0;
        alt_dout[1] = 1; alt_dout[2] = 1; alt_doe[N+0] = 1;
        #1; chk("R5 wrong source", {29'b0, pad_out[2:0]}, 0);
        chk("R5 oe none", {29'b0, pad_oe[2:0]}, 0);
        alt_dout = '0; alt_doe = '0;
        wr(8'h78, 32'h4); wr(8'h58, 32'h6); wr(8'h48, 32'h7);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        wr(8'h74, 32'h8); wr(8'h64, 32'h8); wr(8'h54, 32'h8);
        wr(8'h28, 32'h8); wr(8'h84, 32'hffff_ffff);
        chk("R6 oe off", {31'b0, pad_oe[3]}, 0);
        rd(8'h80, v); chk("R6 no flag idle", v, 0);
        pad_in[3] = 1; idle(4);
        rd(8'h80, v); chk("R6 rising", v, 32'h8);
        chk("R10 irq", {31'b0, irq_out}, 1);
        wr(8'h84, 32'h8); idle(2);
        rd(8'h80, v); chk("R6 edge stays clear", v, 0);
        chk("R10 irq drops", {31'b0, irq_out}, 0);
        wr(8'h68, 32'h8); idle(2);
        rd(8'h80, v); chk("R6 no flag on high", v, 0);
        pad_in[3] = 0; idle(4);
        rd(8'h80, v); chk("R6 falling", v, 32'h8);
        wr(8'h84, 32'h8); wr(8'h24, 32'h8); idle(2);
    endtask

    task automatic t_level_mask();
        logic [31:0] v;
        pad_in[4] = 1; idle(3);
        wr(8'h54, 32'h10); idle(4);
        rd(8'h80, v); chk("R7 no flag high", v, 0);
        pad_in[4] = 0; idle(4);
        rd(8'h80, v); chk("R7 low level", v, 32'h10);
        chk("R10 masked", {31'b0, irq_out}, 0);
        wr(8'h28, 32'h10); idle(1);
        chk("R10 unmasked", {31'b0, irq_out}, 1);
        wr(8'h84, 32'h10);
        rd(8'h80, v); chk("R7 clear while active", v, 32'h10);
        pad_in[4] = 1; idle(4); wr(8'h84, 32'h10); idle(1);
        rd(8'h80, v); chk("R8 clear", v, 0);
        idle(1); chk("R10 irq low", {31'b0, irq_out}, 0);
        wr(8'h58, 32'h10); wr(8'h24, 32'h10);
    endtask

    task automatic t_no_irq_mode();
        logic [31:0] v;
        for (int i = 0; i < 3; i++) begin
            pad_in[6] = 1; idle(3); pad_in[6] = 0; idle(3);
        end
        rd(8'h80, v); chk("R8 gpio pin no flag", v, 0);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3); rst_n = 1; idle(1);
        t_reset();
        t_setclr();
        t_gpio();
        t_pull();
        t_alt();
        t_edge();
        t_level_mask();
        t_no_irq_mode();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule